// File: doc/BRIEF.md
# Clock PLL Operating Mode Controller

This block is the mode state machine of a network-synchronization clock PLL. It decides whether the loop is held in reset, running free on its local oscillator, locked to the chosen reference, or coasting on a frozen frequency word. Coasting happens in one of two holdover states. Manual holdover is requested by control. Automatic holdover is entered on its own when a locked reference fails. From automatic holdover the loop returns to lock without software help, except for an 8 kHz reference, which must first pass through manual holdover.

Control supplies a two-bit mode code. The reference path supplies a reference-good level, the selected reference index and a flag marking an 8 kHz reference. The block reports its state and a combined holdover flag, which also appears at a fixed bit of a status word. It emits one-cycle strobes that tell the loop filter when to freeze its frequency word and when to resume tracking. All outputs are registered and change on the same clock edge as the state.

Top module: `pllmode_ctrl`

## Requirements
- R1: While `rst` is high, the state becomes Reset and every output is zero. The state codes are Reset=0, Free-run=1, Normal=2, Holdover=3, Auto-holdover=4. On the first edge with `rst` low, Reset moves to Free-run, whatever the mode code.
- R2: Mode code 2'b10 moves any state to Free-run on the next edge.
- R3: Mode code 2'b11 keeps any state other than Reset unchanged.
- R4: In Free-run, code 2'b00 moves to Normal. Code 2'b01 keeps Free-run.
- R5: In Normal, code 2'b01 or any change of `ref_sel` moves to Holdover. This takes priority over a reference failure. With code 2'b00, a high-to-low change of `ref_ok` moves to Auto-holdover.
- R6: In Auto-holdover, code 2'b01 or a change of `ref_sel` moves to Holdover. With code 2'b00, a low-to-high change of `ref_ok` moves to Normal, or to Holdover when `ref_is_8k` is high.
- R7: Holdover moves to Normal only when the code is 2'b00, `ref_ok` is high and `ref_sel` is unchanged. Otherwise it stays in Holdover.
- R8: `holdover_o` is high exactly when the state is Holdover or Auto-holdover. `status_o` carries this flag at bit HOLD_BIT (4 by default), and all its other bits are zero.
- R9: `freeze_o` is high for one cycle, in the cycle where the state first enters Holdover or Auto-holdover from a non-holdover state.
- R10: `resume_o` is high for one cycle, in the cycle where the state enters Normal from Holdover or Auto-holdover.
- R11: Only transitions of `ref_ok` act in Normal and Auto-holdover. A steady low level in Normal, or a steady high level in Auto-holdover, causes no move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Mode request: 00 lock, 01 holdover, 10 free-run, 11 no change |
| ref_ok | input | 1 | Selected reference is good |
| ref_sel | input | SEL_W | Index of the selected reference |
| ref_is_8k | input | 1 | Selected reference is an 8 kHz clock |
| state_o | output | 3 | Current state code |
| holdover_o | output | 1 | Combined holdover flag |
| status_o | output | STATUS_W | Status word with the holdover flag at HOLD_BIT |
| freeze_o | output | 1 | Strobe: freeze the loop frequency word |
| resume_o | output | 1 | Strobe: resume loop tracking |

## Verification
Several properties are checked on every cycle: the reset entry, forced free-run, the hold behaviour of code 11, agreement between the holdover flag, the status bit and the state, the strobe conditions, and the rule that an 8 kHz recovery never lands directly in Normal. Other behaviour depends on input history and can only be shown by the bench scenarios. This covers which transition each state takes for each combination of mode code, previous and present `ref_ok`, reference change and frequency class. It also covers the priority of a reference change over a failure, the two-step 8 kHz recovery, and the lack of any response to a steady `ref_ok` level.

// File: rtl/pllmode_pkg.sv
package pllmode_pkg;

  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_FREERUN  = 3'd1,
    ST_NORMAL   = 3'd2,
    ST_HOLDOVER = 3'd3,
    ST_AUTOHOLD = 3'd4
  } pll_state_e;

  localparam logic [1:0] MODE_LOCK = 2'b00;
  localparam logic [1:0] MODE_HOLD = 2'b01;
  localparam logic [1:0] MODE_FREE = 2'b10;
  localparam logic [1:0] MODE_KEEP = 2'b11;

  function automatic logic is_holding(input pll_state_e s);
    return (s == ST_HOLDOVER) || (s == ST_AUTOHOLD);
  endfunction

endpackage

// File: rtl/pllmode_edges.sv
module pllmode_edges #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_ok,
  input  logic [SEL_W-1:0] ref_sel,
  output logic             ok_rise,
  output logic             ok_fall,
  output logic             sel_chg
);
  logic             ok_q;
  logic [SEL_W-1:0] sel_q;

  // Registered copies are loaded during reset too, so no spurious edge at release.
  always_ff @(posedge clk) begin
    ok_q  <= ref_ok;
    sel_q <= ref_sel;
  end

  always_comb begin
    ok_rise = ~rst & ~ok_q & ref_ok;
    ok_fall = ~rst & ok_q & ~ref_ok;
    sel_chg = ~rst & (sel_q != ref_sel);
  end
endmodule

// File: rtl/pllmode_next.sv
module pllmode_next
  import pllmode_pkg::*;
(
  input  logic       rst,
  input  pll_state_e cur,
  input  logic [1:0] mode_sel,
  input  logic       ref_ok,
  input  logic       ok_rise,
  input  logic       ok_fall,
  input  logic       sel_chg,
  input  logic       ref_is_8k,
  output pll_state_e nxt
);
  always_comb begin
    nxt = cur;
    if (rst) begin
      nxt = ST_RESET;
    end else if (cur == ST_RESET) begin
      nxt = ST_FREERUN;
    end else if (mode_sel == MODE_FREE) begin
      nxt = ST_FREERUN;
    end else if (mode_sel != MODE_KEEP) begin
      unique case (cur)
        ST_FREERUN:
          if (mode_sel == MODE_LOCK) nxt = ST_NORMAL;
        ST_NORMAL:
          if (mode_sel == MODE_HOLD || sel_chg) nxt = ST_HOLDOVER;
          else if (ok_fall)                     nxt = ST_AUTOHOLD;
        ST_AUTOHOLD:
          if (mode_sel == MODE_HOLD || sel_chg) nxt = ST_HOLDOVER;
          else if (ok_rise)                     nxt = ref_is_8k ? ST_HOLDOVER : ST_NORMAL;
        ST_HOLDOVER:
          if (mode_sel == MODE_LOCK && ref_ok && !sel_chg) nxt = ST_NORMAL;
        default: nxt = ST_RESET;
      endcase
    end
  end
endmodule

// File: rtl/pllmode_ctrl.sv
module pllmode_ctrl
  import pllmode_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int STATUS_W = 8,
  parameter int HOLD_BIT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode_sel,
  input  logic                ref_ok,
  input  logic [SEL_W-1:0]    ref_sel,
  input  logic                ref_is_8k,
  output logic [2:0]          state_o,
  output logic                holdover_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                freeze_o,
  output logic                resume_o
);
  localparam int HB = (HOLD_BIT < STATUS_W) ? HOLD_BIT : STATUS_W - 1;

  logic       ok_rise, ok_fall, sel_chg;
  pll_state_e state_q, nxt;
  logic       hold_q, freeze_q, resume_q;
  logic [STATUS_W-1:0] status_q;

  pllmode_edges #(.SEL_W(SEL_W)) u_edges (
    .clk(clk), .rst(rst), .ref_ok(ref_ok), .ref_sel(ref_sel),
    .ok_rise(ok_rise), .ok_fall(ok_fall), .sel_chg(sel_chg)
  );

  pllmode_next u_next (
    .rst(rst), .cur(state_q), .mode_sel(mode_sel), .ref_ok(ref_ok),
    .ok_rise(ok_rise), .ok_fall(ok_fall), .sel_chg(sel_chg),
    .ref_is_8k(ref_is_8k), .nxt(nxt)
  );

  // All outputs are decoded from the next state so they move with state_q.
  always_ff @(posedge clk) begin
    state_q      <= nxt;
    hold_q       <= is_holding(nxt);
    freeze_q     <= is_holding(nxt) & ~is_holding(state_q);
    resume_q     <= (nxt == ST_NORMAL) & is_holding(state_q);
    status_q     <= '0;
    status_q[HB] <= is_holding(nxt);
  end

  assign state_o    = state_q;
  assign holdover_o = hold_q;
  assign status_o   = status_q;
  assign freeze_o   = freeze_q;
  assign resume_o   = resume_q;
endmodule

// File: rtl/pllmode_chk.sv
module pllmode_chk
  import pllmode_pkg::*;
#(
  parameter int STATUS_W = 8,
  parameter int HOLD_BIT = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          mode_sel,
  input logic                ref_is_8k,
  input logic [2:0]          state_o,
  input logic                holdover_o,
  input logic [STATUS_W-1:0] status_o,
  input logic                freeze_o,
  input logic                resume_o
);
  logic hold_st;
  assign hold_st = (state_o == 3'(ST_HOLDOVER)) || (state_o == 3'(ST_AUTOHOLD));

  AST_RESET_ENTRY: assert property (@(posedge clk)
    rst |=> (state_o == 3'(ST_RESET)) && !holdover_o && !freeze_o && !resume_o); // R1

  AST_FORCE_FREERUN: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == MODE_FREE) |=> (state_o == 3'(ST_FREERUN))); // R2

  AST_CODE11_KEEP: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == MODE_KEEP && state_o != 3'(ST_RESET)) |=> $stable(state_o)); // R3

  AST_8K_VIA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'(ST_AUTOHOLD) && ref_is_8k) |=> (state_o != 3'(ST_NORMAL))); // R6

  AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (rst)
    holdover_o == hold_st); // R8

  AST_STATUS_BIT: assert property (@(posedge clk) disable iff (rst)
    (status_o[HOLD_BIT] == holdover_o) && ($countones(status_o) == int'(holdover_o))); // R8

  AST_FREEZE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    freeze_o |-> (holdover_o && !$past(holdover_o))); // R9

  AST_RESUME_ENTRY: assert property (@(posedge clk) disable iff (rst)
    resume_o |-> (state_o == 3'(ST_NORMAL) && $past(holdover_o))); // R10
endmodule

bind pllmode_ctrl pllmode_chk #(.STATUS_W(STATUS_W), .HOLD_BIT(HOLD_BIT)) u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .ref_is_8k(ref_is_8k),
  .state_o(state_o), .holdover_o(holdover_o), .status_o(status_o),
  .freeze_o(freeze_o), .resume_o(resume_o)
);

// File: tb/tb_pllmode_ctrl.sv
`timescale 1ns/1ps
module tb_pllmode_ctrl;
  localparam int SW = 2, STW = 8, HB = 4;
  localparam int S_RST = 0, S_FR = 1, S_NRM = 2, S_HO = 3, S_AH = 4;

  logic clk = 1'b0, rst = 1'b1, ref_ok = 1'b0, ref_is_8k = 1'b0;
  logic [1:0] mode_sel = 2'b10;
  logic [SW-1:0] ref_sel = '0;
  logic [2:0] state_o;
  logic holdover_o, freeze_o, resume_o;
  logic [STW-1:0] status_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pllmode_ctrl #(.SEL_W(SW), .STATUS_W(STW), .HOLD_BIT(HB)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .ref_ok(ref_ok), .ref_sel(ref_sel),
    .ref_is_8k(ref_is_8k), .state_o(state_o), .holdover_o(holdover_o),
    .status_o(status_o), .freeze_o(freeze_o), .resume_o(resume_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic bit holding(input int s);
    return s == S_HO || s == S_AH;
  endfunction

  function automatic int model(input int s, input int m, input bit rp, input bit rn,
                               input bit chg, input bit k8);
    bit fall = rp & !rn, rise = !rp & rn;
    if (m == 2) return S_FR;
    if (m == 3) return s;
    case (s)
      S_FR:  return (m == 0) ? S_NRM : S_FR;
      S_NRM: return (m == 1 || chg) ? S_HO : (fall ? S_AH : S_NRM);
      S_AH:  return (m == 1 || chg) ? S_HO : (rise ? (k8 ? S_HO : S_NRM) : S_AH);
      default: return (m == 0 && rn && !chg) ? S_NRM : S_HO;
    endcase
  endfunction

  function automatic string tag_of(input int s, input int m, input bit rp, input bit rn);
    if (m == 2) return "R2";
    if (m == 3) return "R3";
    if (rp == rn && ((s == S_NRM && !rn) || (s == S_AH && rn))) return "R11";
    case (s)
      S_FR: return "R4"; S_NRM: return "R5"; S_AH: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Reset, then reach state st with the registered ref_ok copy equal to rp.
  task automatic goto(input int st, input bit rp);
    rst = 1; mode_sel = 2'b10; ref_ok = 1; ref_sel = '0; ref_is_8k = 0; step();
    rst = 0; step();
    if (st != S_FR) begin
      mode_sel = 2'b00; step();
      if (st == S_HO) begin mode_sel = 2'b01; step(); end
      if (st == S_AH) begin ref_ok = 0; step(); end
    end
    mode_sel = 2'b11; ref_ok = rp; step();
  endtask

  initial begin
    @(negedge clk);
    rst = 1; step();
    chk("R1 reset state", state_o, S_RST);
    chk("R1 reset flags", {holdover_o, freeze_o, resume_o}, 0);
    chk("R1 reset status", status_o, 0);
    rst = 0; mode_sel = 2'b11; step();
    chk("R1 release to free-run", state_o, S_FR);

    for (int s = 1; s <= 4; s++)
      for (int m = 0; m < 4; m++)
        for (int rp = 0; rp < 2; rp++)
          for (int rn = 0; rn < 2; rn++)
            for (int c = 0; c < 2; c++)
              for (int k = 0; k < 2; k++) begin
                int e;
                string t;
                goto(s, rp[0]);
                chk("setup", state_o, s);
                mode_sel = m[1:0]; ref_ok = rn[0]; ref_sel = c[0] ? 2'b01 : 2'b00;
                ref_is_8k = k[0];
                step();
                e = model(s, m, rp[0], rn[0], c[0], k[0]);
                t = tag_of(s, m, rp[0], rn[0]);
                chk(t, state_o, e);
                chk("R8 holdover flag", holdover_o, holding(e));
                chk("R8 status word", status_o, holding(e) ? (1 << HB) : 0);
                chk("R9 freeze strobe", freeze_o, holding(e) && !holding(s));
                chk("R10 resume strobe", resume_o, e == S_NRM && holding(s));
              end

    // 8 kHz recovery: Auto-holdover -> Holdover -> Normal.
    goto(S_AH, 1'b0);
    mode_sel = 2'b00; ref_is_8k = 1; ref_ok = 1; step();
    chk("R6 8k recovery to holdover", state_o, S_HO);
    chk("R9 no second freeze", freeze_o, 0);
    step();
    chk("R7 holdover to normal", state_o, S_NRM);
    chk("R10 resume after 8k", resume_o, 1);
    step();
    chk("R10 resume one cycle", resume_o, 0);
    // Freeze strobe lasts one cycle.
    mode_sel = 2'b01; step();
    chk("R9 freeze", freeze_o, 1);
    step();
    chk("R9 freeze one cycle", freeze_o, 0);
    // Reset from a holdover state.
    rst = 1; step();
    chk("R1 reset from holdover", state_o, S_RST);
    rst = 0; mode_sel = 2'b00; step();
    chk("R1 release ignores code", state_o, S_FR);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule